// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block resolves a translation request, made of a 52-bit virtual page number, an 8-bit address space tag and a 4-bit application tag, into a page table entry. The entry is looked up in a single inverted page table held in memory. The table is divided into 65536 groups of 1024 bits. Each group holds a 64-bit header followed by six 160-bit entries. A hash of the application tag and part of the page number selects the first group. The walker reads that group as eight 128-bit beats and checks all six entries in one cycle. When none of them match, it moves on to the next group in a quadratic open-addressing sequence.

A walk starts on a one-cycle `start_i` pulse while the block is idle. It ends with a one-cycle `done_o` pulse. At that pulse `hit_o` shows whether a match was found, and `entry_o` carries the matching entry, or zero on a fault.

The controller uses four states:
- S_IDLE waits for a start.
- S_REQ issues one memory request for the current group.
- S_FILL collects the beats.
- S_CHECK compares the entries.

The transitions are:
- idle-to-request on start.
- request-to-fill after the request cycle.
- fill-to-check on the eighth beat.
- check-to-idle on a hit or when the probe budget is spent.
- check-to-request on any other miss.

Top module: `ipt_walker`

## Requirements
- R1: The first group index is the application tag in bits 15:12 concatenated with page-number bits 13:2 in bits 11:0. Page-number bits 1:0 and 51:14 do not change it. The memory byte address of a group is index × 128.
- R2: After the n-th missed group, the next group searched is (first index + n²) mod 65536, so the sequence is h, h+1, h+4, h+9 and so on, wrapping through zero.
- R3: Each group is fetched with exactly one single-cycle `mem_req_o` followed by eight accepted beats. Beat b supplies group bits 128b+127..128b. Beats may be separated by idle cycles. `mem_rvalid_i` is ignored while no fetch is in progress.
- R4: Group bits 63:0 are a header and are never compared. Entry k occupies group bits 64+160k+159..64+160k. Within an entry, the tag is in bits 31:24 and valid is bit 23. The physical page number is in bits 63:32 (low part) and 83:64 (high part). The virtual page number is in bits 127:96 (low part) and 147:128 (high part).
- R5: An entry matches only when its valid bit is set, its tag equals the request tag, and its virtual page number equals the requested one.
- R6: When several entries in one group match, the entry with the lowest slot number is returned.
- R7: When MAX_PROBES groups (default 8) have missed, the walk ends with `done_o`=1, `hit_o`=0 and `entry_o`=0, and no further request is made.
- R8: A match found in the last permitted group is reported as a hit, not as a fault.
- R9: `done_o` is high for exactly one cycle per walk. `hit_o` and `entry_o` hold their values until the next completion.
- R10: `busy_o` is high from the cycle after an accepted start until completion. A start pulse while busy is ignored.
- R11: After reset, `busy_o`, `done_o`, `hit_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse for a walk |
| vpn_i | input | 52 | Virtual page number to translate |
| asid_i | input | 8 | Address space tag of the request |
| app_id_i | input | 4 | Application tag used for the hash |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | One-cycle group fetch request |
| mem_addr_o | output | 23 | Byte address of the group being fetched |
| mem_rvalid_i | input | 1 | Read beat valid |
| mem_rdata_i | input | 128 | Read beat data |
| done_o | output | 1 | One-cycle completion pulse |
| hit_o | output | 1 | Completion was a hit |
| entry_o | output | 160 | Matching entry, or zero on a fault |

## Verification
Two decisions can fall in the same check cycle: finding a match and running out of probe budget. The bench provokes this by placing the only matching entry in the eighth group of the sequence, and it expects a hit after exactly eight requests, not a fault. A start pulse can also arrive while a walk is in progress. The bench injects one mid-walk with a different page number that has its own entry planted in the table, and it judges the outcome by the returned entry and the request count.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    localparam int ENT_W  = 160;
    localparam int ASID_W = 8;
    localparam int PN_W   = 52;

    function automatic logic [ASID_W-1:0] ent_tag(input logic [ENT_W-1:0] e);
        return e[31:24];
    endfunction

    function automatic logic ent_valid(input logic [ENT_W-1:0] e);
        return e[23];
    endfunction

    function automatic logic [PN_W-1:0] ent_vpn(input logic [ENT_W-1:0] e);
        return {e[147:128], e[127:96]};
    endfunction
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
    parameter int IDX_W = 16,
    parameter int APP_W = 4,
    parameter int VPN_W = 52
) (
    input  logic [APP_W-1:0] app_i,
    input  logic [VPN_W-1:0] vpn_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam int LOW_W = IDX_W - APP_W;

    // page-number bits 1:0 pick neighbouring pages inside one group
    assign idx_o = {app_i, vpn_i[LOW_W+1:2]};

    logic unused_vpn_bits;
    assign unused_vpn_bits = ^{vpn_i[VPN_W-1:LOW_W+2], vpn_i[1:0]};
endmodule

// File: rtl/ipt_fill.sv
module ipt_fill #(
    parameter int BEAT_W = 128,
    parameter int BEATS  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    vld_i,
    input  logic [BEAT_W-1:0]       data_i,
    output logic                    last_o,
    output logic [BEATS*BEAT_W-1:0] group_o
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            cnt_q <= '0;
        else if (vld_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last_o = vld_i && (cnt_q == CW'(BEATS-1));

    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        logic [BEAT_W-1:0] beat_q;
        always_ff @(posedge clk) begin
            if (vld_i && cnt_q == CW'(b))
                beat_q <= data_i;
        end
        assign group_o[b*BEAT_W +: BEAT_W] = beat_q;
    end
endmodule

// File: rtl/ipt_match.sv
module ipt_match
    import ipt_pkg::*;
#(
    parameter int ENTRIES = 6,
    parameter int HDR_W   = 64,
    parameter int GROUP_W = 1024
) (
    input  logic [GROUP_W-1:0] group_i,
    input  logic [PN_W-1:0]    vpn_i,
    input  logic [ASID_W-1:0]  tag_i,
    output logic               hit_o,
    output logic [ENT_W-1:0]   entry_o
);
    logic [ENT_W-1:0]   ent_w [ENTRIES];
    logic [ENTRIES-1:0] eq_w;

    for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
        assign ent_w[k] = group_i[HDR_W + k*ENT_W +: ENT_W];
        assign eq_w[k]  = ent_valid(ent_w[k]) && (ent_tag(ent_w[k]) == tag_i)
                          && (ent_vpn(ent_w[k]) == vpn_i);
    end

    // scan downwards so the lowest matching slot is written last
    always_comb begin
        hit_o   = 1'b0;
        entry_o = '0;
        for (int k = ENTRIES-1; k >= 0; k--) begin
            if (eq_w[k]) begin
                hit_o   = 1'b1;
                entry_o = ent_w[k];
            end
        end
    end

    logic unused_header;
    assign unused_header = ^group_i[HDR_W-1:0];
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
    import ipt_pkg::*;
#(
    parameter int IDX_W      = 16,
    parameter int APP_W      = 4,
    parameter int BEAT_W     = 128,
    parameter int BEATS      = 8,
    parameter int ENTRIES    = 6,
    parameter int HDR_W      = 64,
    parameter int MAX_PROBES = 8,
    localparam int GROUP_W   = BEAT_W * BEATS,
    localparam int OFS_W     = $clog2(GROUP_W / 8),
    localparam int ADDR_W    = IDX_W + OFS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [PN_W-1:0]      vpn_i,
    input  logic [ASID_W-1:0]    asid_i,
    input  logic [APP_W-1:0]     app_id_i,
    output logic                 busy_o,
    output logic                 mem_req_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic                 mem_rvalid_i,
    input  logic [BEAT_W-1:0]    mem_rdata_i,
    output logic                 done_o,
    output logic                 hit_o,
    output logic [ENT_W-1:0]     entry_o
);
    localparam int PRB_W = $clog2(MAX_PROBES + 1);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL, S_CHECK} state_t;

    state_t             state_q, state_d;
    logic [PN_W-1:0]    vpn_q;
    logic [ASID_W-1:0]  tag_q;
    logic [IDX_W-1:0]   idx_q;
    logic [PRB_W-1:0]   miss_q;
    logic [IDX_W-1:0]   hash_w;
    logic               last_w;
    logic [GROUP_W-1:0] group_w;
    logic               match_w;
    logic [ENT_W-1:0]   match_ent_w;
    logic               budget_out_w;

    ipt_hash #(.IDX_W(IDX_W), .APP_W(APP_W), .VPN_W(PN_W)) u_hash (
        .app_i (app_id_i),
        .vpn_i (vpn_i),
        .idx_o (hash_w)
    );

    ipt_fill #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_fill (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state_q == S_REQ),
        .vld_i   (mem_rvalid_i && state_q == S_FILL),
        .data_i  (mem_rdata_i),
        .last_o  (last_w),
        .group_o (group_w)
    );

    ipt_match #(.ENTRIES(ENTRIES), .HDR_W(HDR_W), .GROUP_W(GROUP_W)) u_match (
        .group_i (group_w),
        .vpn_i   (vpn_q),
        .tag_i   (tag_q),
        .hit_o   (match_w),
        .entry_o (match_ent_w)
    );

    assign budget_out_w = (miss_q == PRB_W'(MAX_PROBES - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_i) state_d = S_REQ;
            S_REQ:   state_d = S_FILL;
            S_FILL:  if (last_w) state_d = S_CHECK;
            S_CHECK: state_d = (match_w || budget_out_w) ? S_IDLE : S_REQ;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            hit_o   <= 1'b0;
            entry_o <= '0;
            vpn_q   <= '0;
            tag_q   <= '0;
            idx_q   <= '0;
            miss_q  <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    vpn_q  <= vpn_i;
                    tag_q  <= asid_i;
                    idx_q  <= hash_w;
                    miss_q <= '0;
                end
                S_CHECK: begin
                    if (match_w) begin
                        done_o  <= 1'b1;
                        hit_o   <= 1'b1;
                        entry_o <= match_ent_w;
                    end else if (budget_out_w) begin
                        done_o  <= 1'b1;
                        hit_o   <= 1'b0;
                        entry_o <= '0;
                    end else begin
                        // (n+1)^2 = n^2 + 2n + 1
                        idx_q  <= idx_q + IDX_W'({miss_q, 1'b1});
                        miss_q <= miss_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o     = (state_q != S_IDLE);
    assign mem_req_o  = (state_q == S_REQ);
    assign mem_addr_o = {idx_q, OFS_W'(0)};

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R5
    hit_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && hit_o) |-> (ent_valid(entry_o) && ent_tag(entry_o) == tag_q
                               && ent_vpn(entry_o) == vpn_q));

    // R7
    fault_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !hit_o) |-> (miss_q == PRB_W'(MAX_PROBES - 1)));

    // R10
    hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != S_CHECK) |=> ($stable(vpn_q) && $stable(tag_q)));
endmodule

// File: tb/ipt_walker_test.sv
`timescale 1ns/1ps
module ipt_walker_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [51:0]  vpn_i = '0;
    logic [7:0]   asid_i = '0;
    logic [3:0]   app_id_i = '0;
    logic         busy_o, mem_req_o, done_o, hit_o;
    logic [22:0]  mem_addr_o;
    logic         mem_rvalid_i = 1'b0;
    logic [127:0] mem_rdata_i = '0;
    logic [159:0] entry_o;

    always #2.5 clk = ~clk;

    ipt_walker uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vpn_i(vpn_i),
        .asid_i(asid_i), .app_id_i(app_id_i), .busy_o(busy_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .hit_o(hit_o), .entry_o(entry_o)
    );

    int nchk = 0;
    int nerr = 0;
    int nplant = 0;
    logic [15:0]  plant_grp  [8];
    int           plant_slot [8];
    logic [159:0] plant_ent  [8];
    int           nreq = 0;
    logic [22:0]  req_log [16];
    logic         r_hit;
    logic [159:0] r_ent;
    logic         r_busy;

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] hash_of(input logic [3:0] app, input logic [51:0] vpn);
        return {app, vpn[13:2]};
    endfunction

    function automatic logic [159:0] mk_entry(input logic v, input logic [7:0] tag,
                                              input logic [51:0] vpn, input logic [51:0] ppn);
        logic [159:0] e = '0;
        e[31:24]   = tag;
        e[23]      = v;
        e[7:0]     = 8'h0F;
        e[63:32]   = ppn[31:0];
        e[83:64]   = ppn[51:32];
        e[127:96]  = vpn[31:0];
        e[147:128] = vpn[51:32];
        return e;
    endfunction

    function automatic logic [1023:0] build_group(input logic [15:0] idx);
        logic [1023:0] g = '0;
        g[63:0] = '1;
        for (int p = 0; p < nplant; p++)
            if (plant_grp[p] == idx) g[64 + 160*plant_slot[p] +: 160] = plant_ent[p];
        return g;
    endfunction

    task automatic plant(input logic [15:0] grp, input int slot, input logic [159:0] e);
        plant_grp[nplant] = grp; plant_slot[nplant] = slot; plant_ent[nplant] = e;
        nplant++;
    endtask

    // memory model: one request, then eight beats with a stall before beat 3
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_o) begin
                logic [1023:0] grp;
                if (nreq < 16) req_log[nreq] = mem_addr_o;
                nreq++;
                grp = build_group(mem_addr_o[22:7]);
                for (int b = 0; b < 8; b++) begin
                    if (b == 3) begin
                        @(negedge clk);
                        mem_rvalid_i = 1'b0;
                    end
                    @(negedge clk);
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = grp[b*128 +: 128];
                end
                @(negedge clk);
                mem_rvalid_i = 1'b0;
            end
        end
    end

    task automatic walk(input logic [51:0] vpn, input logic [7:0] tag,
                        input logic [3:0] app, input bit inject);
        int cnt = 0;
        nreq = 0;
        @(negedge clk);
        start_i = 1'b1; vpn_i = vpn; asid_i = tag; app_id_i = app;
        @(negedge clk);
        start_i = 1'b0;
        r_busy = busy_o;
        if (inject) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1; vpn_i = vpn ^ 52'h5555;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!done_o && cnt < 5000) begin
            @(negedge clk);
            cnt++;
        end
        r_hit = hit_o;
        r_ent = entry_o;
        chk("R10 busy low at completion", busy_o, 0);
        @(negedge clk);
        chk("R9 done single pulse", done_o, 0);
        chk("R9 entry held", entry_o, r_ent);
    endtask

    initial begin
        #(5.0 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [51:0] v;
        logic [15:0] h;
        repeat (4) @(negedge clk);
        chk("R11 busy after reset", busy_o, 0);
        chk("R11 done after reset", done_o, 0);
        chk("R11 hit after reset", hit_o, 0);
        chk("R11 req after reset", mem_req_o, 0);
        rst_n = 1'b1;

        // stray read beats while idle
        @(negedge clk);
        mem_rvalid_i = 1'b1; mem_rdata_i = '1;
        repeat (2) @(negedge clk);
        mem_rvalid_i = 1'b0;

        // R1/R4: sweep every slot of the first group
        for (int s = 0; s < 6; s++) begin
            v = 52'hA_BCDE_F000_0000 | 52'(s * 40 + 7);
            h = hash_of(4'(s), v);
            nplant = 0;
            plant(h, s, mk_entry(1'b1, 8'(s + 3), v, 52'(s + 100)));
            walk(v, 8'(s + 3), 4'(s), 1'b0);
            if (s == 0) chk("R3 idle beats ignored", r_ent, mk_entry(1'b1, 8'd3, v, 52'd100));
            chk("R4 slot hit", r_hit, 1);
            chk("R4 slot entry", r_ent, mk_entry(1'b1, 8'(s + 3), v, 52'(s + 100)));
            chk("R1 first address", req_log[0], {h, 7'd0});
            chk("R3 one request", nreq, 1);
            chk("R10 busy after start", r_busy, 1);
        end

        // R1: low page bits do not move the hash
        v = 52'h0_0000_0000_3FF3;
        nplant = 0;
        plant(hash_of(4'h2, v & ~52'h3), 1, mk_entry(1'b1, 8'h44, v, 52'h77));
        walk(v, 8'h44, 4'h2, 1'b0);
        chk("R1 low bits ignored hit", r_hit, 1);
        chk("R1 low bits address", req_log[0], {4'h2, 12'hFFC, 7'd0});

        // R2/R8: hit at probe k, sequence wraps past 65535
        v = 52'h1_0000_0000_3FF9;
        h = hash_of(4'hF, v);
        for (int k = 0; k < 8; k++) begin
            nplant = 0;
            plant(16'(h + 16'(k * k)), k % 6, mk_entry(1'b1, 8'h21, v, 52'(k)));
            walk(v, 8'h21, 4'hF, 1'b0);
            chk(k == 7 ? "R8 hit on last group" : "R2 hit after probes", r_hit, 1);
            chk("R2 entry", r_ent, mk_entry(1'b1, 8'h21, v, 52'(k)));
            chk("R2 request count", nreq, k + 1);
            for (int j = 0; j <= k; j++)
                chk("R2 probe address", req_log[j], {16'(h + 16'(j * j)), 7'd0});
        end

        // R7: fault when nothing matches; entry off the sequence is not found
        nplant = 0;
        plant(16'(h + 16'd2), 0, mk_entry(1'b1, 8'h21, v, 52'h5));
        walk(v, 8'h21, 4'hF, 1'b0);
        chk("R7 fault hit", r_hit, 0);
        chk("R7 fault entry", r_ent, 0);
        chk("R7 fault request count", nreq, 8);
        repeat (4) @(negedge clk);
        chk("R7 no request after fault", nreq, 8);

        // R5: invalid, wrong tag, wrong page all rejected
        v = 52'h2_2222_0000_0124;
        h = hash_of(4'h6, v);
        nplant = 0;
        plant(h, 0, mk_entry(1'b0, 8'h10, v, 52'h1));
        plant(h, 1, mk_entry(1'b1, 8'h11, v, 52'h2));
        plant(h, 2, mk_entry(1'b1, 8'h10, v ^ 52'h8_0000_0000_0000, 52'h3));
        plant(h, 4, mk_entry(1'b1, 8'h10, v, 52'h4));
        walk(v, 8'h10, 4'h6, 1'b0);
        chk("R5 filtered hit", r_hit, 1);
        chk("R5 filtered entry", r_ent, mk_entry(1'b1, 8'h10, v, 52'h4));

        // R6: lowest slot wins
        nplant = 0;
        plant(h, 5, mk_entry(1'b1, 8'h10, v, 52'h55));
        plant(h, 3, mk_entry(1'b1, 8'h10, v, 52'h33));
        walk(v, 8'h10, 4'h6, 1'b0);
        chk("R6 priority entry", r_ent, mk_entry(1'b1, 8'h10, v, 52'h33));

        // R10: start while busy ignored
        nplant = 0;
        plant(h, 2, mk_entry(1'b1, 8'h10, v, 52'hAA));
        plant(hash_of(4'h6, v ^ 52'h5555), 2, mk_entry(1'b1, 8'h10, v ^ 52'h5555, 52'hBB));
        walk(v, 8'h10, 4'h6, 1'b1);
        chk("R10 stray start entry", r_ent, mk_entry(1'b1, 8'h10, v, 52'hAA));
        chk("R10 stray start requests", nreq, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule